// File: doc/BRIEF.md
# Effective Address Generator

This block turns a decoded addressing mode, up to two operand bytes and the two index registers of an 8-bit processor into the 16-bit address of the data operand. The direct modes (zero page, zero page indexed, absolute and absolute indexed) are pure arithmetic and finish one cycle after the request. The pointer modes fetch a two-byte little-endian pointer from the low part of memory over a byte-wide read port, then form the address from it.

Modes that name no data location raise an error flag instead of an address. These are implied, accumulator, immediate, relative and both indirect jump forms. A request is launched by `start_i` and completes with a single-cycle `done_o`. A new request can be launched in the same cycle that `done_o` is high.

Top module: `eff_addr_gen`

## Requirements
- R1: During and after reset, until the first request completes, `done_o`, `err_o` and `mem_req_o` are 0 and `ea_o` is 0.
- R2: Mode 3 (zero page) and mode 15 (zero page with relative target) return `{8'h00, op_lo_i}`.
- R3: Mode 4 (zero page + X) returns `{8'h00, (op_lo_i + idx_x_i) mod 256}`, so the result always lies in page zero.
- R4: Mode 5 (zero page + Y) returns the 9-bit sum `op_lo_i + idx_y_i`, so a carry lands in page one.
- R5: Mode 9 returns `op_hi_i*256 + op_lo_i`. Mode 10 adds X to that value and mode 11 adds Y, both modulo 65536.
- R6: Modes 0 (implied), 1 (accumulator), 2 (immediate), 12 (absolute indirect), 13 (absolute-X indirect) and 14 (relative) complete after one cycle with `err_o` = 1 and `ea_o` = 0, and issue no memory read.
- R7: Mode 7 (pre-indexed indirect) reads the pointer low byte at `(op_lo_i + X) mod 256` and the high byte at `(op_lo_i + X + 1) mod 256`. It returns `{high, low}`.
- R8: Mode 6 (zero-page indirect) reads the low byte at `op_lo_i` and the high byte at `op_lo_i + 1` without wrapping, so operand 0xFF reads 0x0100. It returns `{high, low}`.
- R9: Mode 8 (post-indexed indirect) reads the same two bytes as mode 6 and returns `{high, low} + Y` modulo 65536.
- R10: A request is taken at the clock edge where `start_i` is 1 and the block is idle. The read port returns data one cycle after `mem_req_o`. A direct or error mode raises `done_o` one cycle after the taking edge. A pointer mode requests the low byte one cycle after that edge and the high byte one cycle after the low byte, then raises `done_o` four cycles after the taking edge. `done_o` lasts one cycle per request, and `err_o` is 0 for every mode not listed in R6.
- R11: `start_i` is ignored while a pointer fetch is in progress. No second `done_o` and no change of address results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a request when idle |
| mode_i | input | 4 | Addressing mode code (see requirements) |
| op_lo_i | input | 8 | First operand byte |
| op_hi_i | input | 8 | Second operand byte |
| idx_x_i | input | 8 | X index register |
| idx_y_i | input | 8 | Y index register |
| mem_req_o | output | 1 | Pointer byte read request |
| mem_addr_o | output | 16 | Pointer byte read address |
| mem_rdata_i | input | 8 | Read data, valid one cycle after the request |
| done_o | output | 1 | Request complete, one cycle |
| err_o | output | 1 | Mode carries no data address, valid with done_o |
| ea_o | output | 16 | Effective address, valid with done_o |

## Verification
Direct and error results are due one cycle after the launching edge. Pointer results are due four cycles after it, with read requests visible in the first and second cycles. The bench drives inputs on the falling edge and then samples at each following falling edge. It counts cycles until `done_o` and compares that count with 1 or 4. It also checks the request addresses it saw and confirms that `done_o` has dropped one cycle later. Its memory model answers each request on the next rising edge with a byte computed from the address, so expected pointers are derived arithmetically.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 8;

  typedef enum logic [3:0] {
    AM_IMPL  = 4'd0,
    AM_ACC   = 4'd1,
    AM_IMM   = 4'd2,
    AM_ZPG   = 4'd3,
    AM_ZPGX  = 4'd4,
    AM_ZPGY  = 4'd5,
    AM_IZP   = 4'd6,
    AM_IZPX  = 4'd7,
    AM_IZPY  = 4'd8,
    AM_ABS   = 4'd9,
    AM_ABSX  = 4'd10,
    AM_ABSY  = 4'd11,
    AM_JIND  = 4'd12,
    AM_JINDX = 4'd13,
    AM_REL   = 4'd14,
    AM_ZPREL = 4'd15
  } am_e;

  typedef enum logic [1:0] {
    CL_DIRECT = 2'd0,
    CL_PTR    = 2'd1,
    CL_NONE   = 2'd2
  } am_cls_e;

  typedef struct packed {
    am_cls_e cls;
    logic    pre_x;   // pointer location indexed by X, wraps in page zero
    logic    post_y;  // Y added to the fetched pointer
  } am_info_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LO   = 2'd1,
    SQ_HI   = 2'd2,
    SQ_WAIT = 2'd3
  } sq_state_e;
endpackage

// File: rtl/eag_mode_dec.sv
module eag_mode_dec
  import eag_pkg::*;
(
  input  logic [3:0] mode_i,
  output am_info_t   info_o
);
  always_comb begin
    info_o = '{cls: CL_NONE, pre_x: 1'b0, post_y: 1'b0};
    unique case (am_e'(mode_i))
      AM_ZPG, AM_ZPGX, AM_ZPGY, AM_ZPREL,
      AM_ABS, AM_ABSX, AM_ABSY:  info_o.cls = CL_DIRECT;
      AM_IZP:                    info_o.cls = CL_PTR;
      AM_IZPX: begin
        info_o.cls   = CL_PTR;
        info_o.pre_x = 1'b1;
      end
      AM_IZPY: begin
        info_o.cls    = CL_PTR;
        info_o.post_y = 1'b1;
      end
      default:                   info_o.cls = CL_NONE;
    endcase
  end
endmodule

// File: rtl/eag_direct_calc.sv
module eag_direct_calc
  import eag_pkg::*;
#(
  parameter int unsigned A_W = AW,
  parameter int unsigned D_W = DW
) (
  input  logic [3:0]     mode_i,
  input  logic [D_W-1:0] op_lo_i,
  input  logic [D_W-1:0] op_hi_i,
  input  logic [D_W-1:0] idx_x_i,
  input  logic [D_W-1:0] idx_y_i,
  output logic [A_W-1:0] addr_o
);
  localparam int unsigned HW = A_W - D_W;

  logic [A_W-1:0] abs_base;
  logic [D_W-1:0] zpx_sum;
  logic [D_W:0]   zpy_sum;

  assign abs_base = {op_hi_i[HW-1:0], op_lo_i};
  assign zpx_sum  = op_lo_i + idx_x_i;                   // carry dropped
  assign zpy_sum  = {1'b0, op_lo_i} + {1'b0, idx_y_i};   // carry kept

  always_comb begin
    addr_o = '0;
    unique case (am_e'(mode_i))
      AM_ZPG, AM_ZPREL: addr_o = {{HW{1'b0}}, op_lo_i};
      AM_ZPGX:          addr_o = {{HW{1'b0}}, zpx_sum};
      AM_ZPGY:          addr_o = {{(HW-1){1'b0}}, zpy_sum};
      AM_ABS:           addr_o = abs_base;
      AM_ABSX:          addr_o = abs_base + {{HW{1'b0}}, idx_x_i};
      AM_ABSY:          addr_o = abs_base + {{HW{1'b0}}, idx_y_i};
      default:          addr_o = '0;
    endcase
  end
endmodule

// File: rtl/eag_ptr_seq.sv
module eag_ptr_seq
  import eag_pkg::*;
#(
  parameter int unsigned A_W = AW,
  parameter int unsigned D_W = DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           launch_i,
  input  am_info_t       info_i,
  input  logic [D_W-1:0] op_lo_i,
  input  logic [D_W-1:0] idx_x_i,
  input  logic [D_W-1:0] idx_y_i,
  output logic           busy_o,
  output logic           mem_req_o,
  output logic [A_W-1:0] mem_addr_o,
  input  logic [D_W-1:0] mem_rdata_i,
  output logic           fin_o,
  output logic [A_W-1:0] ptr_ea_o
);
  localparam int unsigned HW = A_W - D_W;

  sq_state_e      state_q, state_d;
  logic [A_W-1:0] lo_addr_q, hi_addr_q;
  logic [D_W-1:0] lo_byte_q, yadd_q;
  logic [A_W-1:0] lo_addr_d, hi_addr_d;
  logic [D_W-1:0] base_sum, base_inc;

  assign base_sum = info_i.pre_x ? D_W'(op_lo_i + idx_x_i) : op_lo_i;
  assign base_inc = base_sum + 1'b1;

  always_comb begin
    lo_addr_d = {{HW{1'b0}}, base_sum};
    if (info_i.pre_x) hi_addr_d = {{HW{1'b0}}, base_inc};   // stays in page zero
    else              hi_addr_d = lo_addr_d + 1'b1;          // may reach page one
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (launch_i) state_d = SQ_LO;
      SQ_LO:   state_d = SQ_HI;
      SQ_HI:   state_d = SQ_WAIT;
      SQ_WAIT: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SQ_IDLE;
      lo_addr_q <= '0;
      hi_addr_q <= '0;
      lo_byte_q <= '0;
      yadd_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SQ_IDLE && launch_i) begin
        lo_addr_q <= lo_addr_d;
        hi_addr_q <= hi_addr_d;
        yadd_q    <= info_i.post_y ? idx_y_i : '0;
      end
      if (state_q == SQ_HI) lo_byte_q <= mem_rdata_i;
    end
  end

  assign busy_o     = (state_q != SQ_IDLE);
  assign mem_req_o  = (state_q == SQ_LO) || (state_q == SQ_HI);
  assign mem_addr_o = (state_q == SQ_LO) ? lo_addr_q :
                      (state_q == SQ_HI) ? hi_addr_q : '0;
  assign fin_o      = (state_q == SQ_WAIT);
  assign ptr_ea_o   = {mem_rdata_i[HW-1:0], lo_byte_q} + {{HW{1'b0}}, yadd_q};
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int unsigned A_W = AW,
  parameter int unsigned D_W = DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [3:0]     mode_i,
  input  logic [D_W-1:0] op_lo_i,
  input  logic [D_W-1:0] op_hi_i,
  input  logic [D_W-1:0] idx_x_i,
  input  logic [D_W-1:0] idx_y_i,
  output logic           mem_req_o,
  output logic [A_W-1:0] mem_addr_o,
  input  logic [D_W-1:0] mem_rdata_i,
  output logic           done_o,
  output logic           err_o,
  output logic [A_W-1:0] ea_o
);
  am_info_t       info;
  logic [A_W-1:0] direct_ea, ptr_ea;
  logic           busy, fin, accept, launch_ptr;

  eag_mode_dec u_dec (
    .mode_i (mode_i),
    .info_o (info)
  );

  eag_direct_calc #(.A_W(A_W), .D_W(D_W)) u_direct (
    .mode_i  (mode_i),
    .op_lo_i (op_lo_i),
    .op_hi_i (op_hi_i),
    .idx_x_i (idx_x_i),
    .idx_y_i (idx_y_i),
    .addr_o  (direct_ea)
  );

  assign accept     = start_i && !busy;
  assign launch_ptr = accept && (info.cls == CL_PTR);

  eag_ptr_seq #(.A_W(A_W), .D_W(D_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch_ptr),
    .info_i      (info),
    .op_lo_i     (op_lo_i),
    .idx_x_i     (idx_x_i),
    .idx_y_i     (idx_y_i),
    .busy_o      (busy),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .fin_o       (fin),
    .ptr_ea_o    (ptr_ea)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      ea_o   <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (fin) begin
        done_o <= 1'b1;
        ea_o   <= ptr_ea;
      end else if (accept && info.cls != CL_PTR) begin
        done_o <= 1'b1;
        err_o  <= (info.cls == CL_NONE);
        ea_o   <= (info.cls == CL_NONE) ? '0 : direct_ea;
      end
    end
  end
endmodule

// File: rtl/eag_checker.sv
module eag_checker
  import eag_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_i,
  input logic [3:0]  mode_i,
  input logic [7:0]  op_lo_i,
  input logic        mem_req_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] ea_o
);
  logic take;
  assign take = start_i && !busy_i;

  a_r2_zpg_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (mode_i == AM_ZPG || mode_i == AM_ZPREL)) |=>
      (done_o && !err_o && ea_o == {8'h00, $past(op_lo_i)}));

  a_r3_zpgx_page0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_i == AM_ZPGX) |=> (done_o && ea_o[15:8] == 8'h00));

  a_r4_zpgy_page01: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && mode_i == AM_ZPGY) |=> (done_o && ea_o[15:9] == 7'h00));

  a_r6_no_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (mode_i <= AM_IMM || mode_i == AM_JIND || mode_i == AM_JINDX || mode_i == AM_REL))
      |=> (done_o && err_o && ea_o == 16'h0 && !mem_req_o));

  a_r6_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r10_req_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |=> mem_req_o);

  a_r10_req_two_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |=> !mem_req_o);

  a_r11_no_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);
endmodule

bind eff_addr_gen eag_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_i    (busy),
  .mode_i    (mode_i),
  .op_lo_i   (op_lo_i),
  .mem_req_o (mem_req_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .ea_o      (ea_o)
);

// File: tb/eff_addr_gen_tb.sv
module eff_addr_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [7:0]  op_lo_i = '0, op_hi_i = '0, idx_x_i = '0, idx_y_i = '0;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        done_o, err_o;
  logic [15:0] ea_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  eff_addr_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .op_lo_i(op_lo_i), .op_hi_i(op_hi_i), .idx_x_i(idx_x_i), .idx_y_i(idx_y_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .err_o(err_o), .ea_o(ea_o)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return 8'(a[7:0] * 8'd29 + a[15:8] * 8'd7 + 8'd3);
  endfunction

  // one-cycle read latency
  always @(posedge clk_i) if (mem_req_o) mem_rdata_i <= mem_fn(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd3, 4'd15:      return "R2";
      4'd4:             return "R3";
      4'd5:             return "R4";
      4'd9, 4'd10, 4'd11: return "R5";
      4'd7:             return "R7";
      4'd6:             return "R8";
      4'd8:             return "R9";
      default:          return "R6";
    endcase
  endfunction

  task automatic run_case(input logic [3:0] m, input logic [7:0] lo, hi, x, y);
    logic [15:0] e_ea, a0, a1, ptr;
    logic [15:0] reqs [4];
    bit e_err, e_ptr, got;
    int e_cyc, cyc, nreq;
    logic [15:0] g_ea;
    logic g_err;
    string t;
    t = tag_of(m);
    e_err = 1'b0; e_ptr = 1'b0; e_ea = '0; a0 = '0; a1 = '0;
    case (m)
      4'd3, 4'd15: e_ea = {8'h00, lo};
      4'd4:  e_ea = {8'h00, 8'(lo + x)};
      4'd5:  e_ea = 16'(lo) + 16'(y);
      4'd9:  e_ea = {hi, lo};
      4'd10: e_ea = {hi, lo} + 16'(x);
      4'd11: e_ea = {hi, lo} + 16'(y);
      4'd6, 4'd8: begin
        e_ptr = 1'b1; a0 = 16'(lo); a1 = 16'(lo) + 16'd1;
      end
      4'd7: begin
        e_ptr = 1'b1; a0 = {8'h00, 8'(lo + x)}; a1 = {8'h00, 8'(lo + x + 8'd1)};
      end
      default: e_err = 1'b1;
    endcase
    if (e_ptr) begin
      ptr  = {mem_fn(a1), mem_fn(a0)};
      e_ea = (m == 4'd8) ? ptr + 16'(y) : ptr;
    end
    e_cyc = e_ptr ? 4 : 1;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = m; op_lo_i = lo; op_hi_i = hi; idx_x_i = x; idx_y_i = y;
    @(negedge clk_i);
    start_i = 1'b0;
    got = 1'b0; cyc = 0; nreq = 0; g_ea = '0; g_err = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      if (mem_req_o && nreq < 4) begin reqs[nreq] = mem_addr_o; nreq++; end
      if (done_o) begin got = 1'b1; cyc = k; g_ea = ea_o; g_err = err_o; break; end
      @(negedge clk_i);
    end
    chk(got && cyc == e_cyc, "R10 done latency", cyc, e_cyc);
    chk(g_ea == e_ea, {t, " address"}, g_ea, e_ea);
    chk(g_err == e_err, {t, " error flag"}, g_err, e_err);
    chk(nreq == (e_ptr ? 2 : 0), {t, " read count"}, nreq, e_ptr ? 2 : 0);
    if (e_ptr && nreq == 2) begin
      chk(reqs[0] == a0, {t, " low pointer read address"}, reqs[0], a0);
      chk(reqs[1] == a1, {t, " high pointer read address"}, reqs[1], a1);
    end
    @(negedge clk_i);
    chk(!done_o, "R10 done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] xv [4];
    xv[0] = 8'h00; xv[1] = 8'h01; xv[2] = 8'h80; xv[3] = 8'hFF;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!done_o && !err_o && !mem_req_o && ea_o == 0, "R1 in reset", {done_o, err_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!done_o && !err_o && !mem_req_o && ea_o == 0, "R1 after reset", ea_o, 0);

    // R2 R3 R4: full operand sweep
    for (int lo = 0; lo < 256; lo++)
      for (int i = 0; i < 4; i++) begin
        run_case(4'd4, 8'(lo), 8'h5A, xv[i], 8'h33);
        run_case(4'd5, 8'(lo), 8'h5A, 8'h33, xv[i]);
        if (i == 0) begin
          run_case(4'd3, 8'(lo), 8'hC3, 8'h11, 8'h22);
          run_case(4'd15, 8'(lo), 8'h3C, 8'h11, 8'h22);
        end
      end

    // R5 absolute forms, including 16-bit wrap
    for (int lo = 0; lo < 256; lo += 17)
      for (int h = 0; h < 4; h++)
        for (int i = 0; i < 4; i++) begin
          run_case(4'd9,  8'(lo), xv[h], xv[i], 8'h00);
          run_case(4'd10, 8'(lo), xv[h], xv[i], 8'h07);
          run_case(4'd11, 8'(lo), xv[h], 8'h07, xv[i]);
        end

    // R6 modes without a data address
    for (int lo = 0; lo < 256; lo += 51) begin
      run_case(4'd0,  8'(lo), 8'h12, 8'h34, 8'h56);
      run_case(4'd1,  8'(lo), 8'h12, 8'h34, 8'h56);
      run_case(4'd2,  8'(lo), 8'h12, 8'h34, 8'h56);
      run_case(4'd12, 8'(lo), 8'h12, 8'h34, 8'h56);
      run_case(4'd13, 8'(lo), 8'h12, 8'h34, 8'h56);
      run_case(4'd14, 8'(lo), 8'h12, 8'h34, 8'h56);
    end

    // R7 R8 R9 pointer forms, incl. page-zero edge
    for (int lo = 0; lo < 256; lo += 15)
      for (int i = 0; i < 4; i++) begin
        run_case(4'd7, 8'(lo), 8'hAA, xv[i], 8'h44);
        run_case(4'd6, 8'(lo), 8'hAA, 8'h44, xv[i]);
        run_case(4'd8, 8'(lo), 8'hAA, 8'h44, xv[i]);
      end
    run_case(4'd6, 8'hFF, 8'h00, 8'h00, 8'h00);
    run_case(4'd8, 8'hFF, 8'h00, 8'h00, 8'hFF);
    run_case(4'd7, 8'hFE, 8'h00, 8'h01, 8'h00);
    run_case(4'd7, 8'h10, 8'h00, 8'hEF, 8'h00);

    // R11 start while a pointer fetch is in flight
    begin
      logic [15:0] e_ea;
      int ndone;
      logic [15:0] last_ea;
      e_ea = {mem_fn(16'h0021), mem_fn(16'h0020)};
      @(negedge clk_i);
      start_i = 1'b1; mode_i = 4'd6; op_lo_i = 8'h20;
      @(negedge clk_i);
      mode_i = 4'd9; op_lo_i = 8'h77; op_hi_i = 8'h66;  // start_i still high, busy
      @(negedge clk_i);
      @(negedge clk_i);
      start_i = 1'b0;
      ndone = 0; last_ea = '0;
      for (int k = 0; k < 6; k++) begin
        if (done_o) begin ndone++; last_ea = ea_o; end
        @(negedge clk_i);
      end
      chk(ndone == 1, "R11 single done", ndone, 1);
      chk(last_ea == e_ea, "R11 address unaffected", last_ea, e_ea);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule